// File: doc/BRIEF.md
# Sound Event Interrupt Controller

This block gathers event requests from eight numbered sound-subsystem sources into a pending mask. It raises a single fast-interrupt line toward the embedded sound processor. It keeps a current-event register that firmware reads to learn which event to service. Firmware retires events by writing a clear register, but only every fourth such write has any effect. Each effective clear retires the lowest pending event and moves the current-event register to the next pending event above it.

The same register block controls the processor's run state. A run-control register whose bit 0 is 1 holds the processor stopped. When a write changes that bit from 1 to 0, the block emits a one-cycle core-reset pulse and lets the processor run. The remaining register addresses are plain storage. Writes take one cycle and use an address, data and write strobe. Reads are combinational from a separate read address.

The current-event register is updated only when something happens, and never recomputed from the mask. This is intended behaviour, so its value can differ from the lowest pending bit.

Top module: `snd_evt_irq_ctrl`

## Requirements
- R1: A high bit k on `evt_req` sets bit k of the pending mask at the next clock edge. A request in the same cycle as an effective clear is applied after the clear, so it is never lost.
- R2: `fiq_o` goes high one cycle after any request and stays high while events remain pending.
- R3: For each requested event number e, the current-event register (address 1) is loaded with e if it reads zero or if e is smaller than its value. Requests in one cycle are applied in ascending order of e, each rule check seeing the result of the previous one. They are also applied after any same-cycle register write.
- R4: Each write to the clear address (address 0) advances a modulo-4 counter. Only the write that brings the counter back to 0 is an effective clear.
- R5: An effective clear removes only the lowest-numbered set bit of the pending mask.
- R6: After an effective clear, if a higher pending bit remains, the lowest such number is written to the current-event register. Otherwise that register keeps its value.
- R7: `fiq_o` falls one cycle after an effective clear that leaves the pending mask empty, unless a request arrives in that same cycle.
- R8: Bit 0 of the run-control register (address 2) stops the processor while it is 1, and `core_run_o` is its inverse. A write that takes bit 0 from 1 to 0 gives a one-cycle high on `core_rst_o` in the following cycle. Any other write gives no pulse.
- R9: Writes to address 1, and to addresses 3 to 7, store the full data word, which reads back unchanged. Address 0 reads as zero.
- R10: After reset the pending mask, clear counter and current-event register are zero. The run-control register is 1, `fiq_o` is 0 and `core_rst_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_req | input | 8 | Per-event request pulses, bit k is event k |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| fiq_o | output | 1 | Fast-interrupt request to the processor |
| core_rst_o | output | 1 | One-cycle processor core-reset pulse |
| core_run_o | output | 1 | High while the processor may run |

## Verification
Requests are applied one at a time in descending, ascending and mixed order. This separates the rule that keeps the smaller number from a plain last-writer update. Requests for event 0 and a higher event in the same cycle expose the zero-reads-as-empty quirk, which leaves the higher number in the register. Runs of clear writes show that the first three writes of each group change nothing. They also show that the fourth retires exactly one event, that the register moves upward or stays unchanged when the mask empties, and that a request arriving with an effective clear survives. Run-control writes of 1→0, 0→0 and 1→1→0 separate true falling-edge detection from a pulse produced on every write of zero.

// File: rtl/snd_irq_pkg.sv
package snd_irq_pkg;

    localparam int N_EVT    = 8;
    localparam int EVT_W    = $clog2(N_EVT);
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int N_REGS   = 1 << ADDR_W;
    localparam int CLR_DIV  = 4;
    localparam int CNT_W    = $clog2(CLR_DIV);

    localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CUR   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_RUN   = ADDR_W'(2);
    localparam int FIRST_SCRATCH = 3;
    localparam int N_SCRATCH     = N_REGS - FIRST_SCRATCH;

    typedef logic [N_EVT-1:0]  evt_mask_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        word_t             data;
    } wr_req_t;

    // index of the lowest set bit; N_EVT when none is set
    function automatic int lowest_set(input evt_mask_t m);
        int idx;
        idx = N_EVT;
        for (int i = N_EVT - 1; i >= 0; i--) begin
            if (m[i]) idx = i;
        end
        return idx;
    endfunction

    function automatic evt_mask_t drop_lowest(input evt_mask_t m);
        return m & (m - evt_mask_t'(1));
    endfunction

endpackage

// File: rtl/evt_pending_unit.sv
module evt_pending_unit
    import snd_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  evt_mask_t req,
    input  logic      clr_wr,
    input  logic      cur_wr,
    input  word_t     cur_wdata,
    output word_t     cur_q,
    output logic      fiq_q
);

    evt_mask_t          pend_q, pend_n;
    logic [CNT_W-1:0]   cnt_q, cnt_n;
    word_t              cur_n;
    logic               fiq_n;
    logic               eff_clr;
    evt_mask_t          after_clr;

    always_comb begin
        cnt_n   = cnt_q;
        eff_clr = 1'b0;
        if (clr_wr) begin
            if (cnt_q == CNT_W'(CLR_DIV - 1)) begin
                cnt_n   = '0;
                eff_clr = 1'b1;
            end else begin
                cnt_n = cnt_q + CNT_W'(1);
            end
        end
    end

    always_comb begin
        cur_n     = cur_wr ? cur_wdata : cur_q;
        fiq_n     = fiq_q;
        after_clr = pend_q;
        if (eff_clr) begin
            after_clr = drop_lowest(pend_q);
            if (after_clr != '0)
                cur_n = word_t'(lowest_set(after_clr));
            else
                fiq_n = 1'b0;
        end
        pend_n = after_clr | req;
        for (int e = 0; e < N_EVT; e++) begin
            if (req[e]) begin
                fiq_n = 1'b1;
                if (cur_n == '0 || word_t'(e) < cur_n)
                    cur_n = word_t'(e);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            cnt_q  <= '0;
            cur_q  <= '0;
            fiq_q  <= 1'b0;
        end else begin
            pend_q <= pend_n;
            cnt_q  <= cnt_n;
            cur_q  <= cur_n;
            fiq_q  <= fiq_n;
        end
    end

    // R2 / R7: interrupt line mirrors a non-empty mask
    a_r7_fiq_tracks_mask: assert property (@(posedge clk) disable iff (rst)
        fiq_q == (pend_q != '0));

    // R4: counter stays within the divider range
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < CLR_DIV);

    // R1: every request bit is pending one cycle later
    generate
        for (genvar k = 0; k < N_EVT; k++) begin : g_req_chk
            a_r1_req_lands: assert property (@(posedge clk) disable iff (rst)
                req[k] |=> pend_q[k]);
        end
    endgenerate

    // R5: an effective clear with no request retires exactly one bit
    a_r5_one_bit_retired: assert property (@(posedge clk) disable iff (rst)
        (eff_clr && req == '0 && pend_q != '0) |=>
            $countones(pend_q) == $countones($past(pend_q)) - 1);

    // R4: the first three clear writes leave the mask unchanged
    a_r4_no_early_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !eff_clr && req == '0) |=> $stable(pend_q));

endmodule

// File: rtl/run_ctrl_unit.sv
module run_ctrl_unit
    import snd_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run_wr,
    input  word_t run_wdata,
    output word_t run_q,
    output logic  core_rst_q
);

    logic start_edge;

    assign start_edge = run_wr && run_q[0] && !run_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q      <= word_t'(1);
            core_rst_q <= 1'b0;
        end else begin
            core_rst_q <= start_edge;
            if (run_wr) run_q <= run_wdata;
        end
    end

    // R8: reset pulse lasts a single cycle
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
        core_rst_q |=> !core_rst_q);

    // R8: pulse only follows a release of the hold bit
    a_r8_pulse_on_release: assert property (@(posedge clk) disable iff (rst)
        core_rst_q |-> (!run_q[0] && $past(run_q[0])));

endmodule

// File: rtl/scratch_regs.sv
module scratch_regs
    import snd_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_word
);

    word_t store_q [N_SCRATCH];

    generate
        for (genvar s = 0; s < N_SCRATCH; s++) begin : g_slot
            localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(FIRST_SCRATCH + s);
            always_ff @(posedge clk) begin
                if (rst)
                    store_q[s] <= '0;
                else if (wr.en && wr.addr == SLOT_ADDR)
                    store_q[s] <= wr.data;
            end
        end
    endgenerate

    always_comb begin
        rd_word = '0;
        for (int s = 0; s < N_SCRATCH; s++) begin
            if (rd_addr == ADDR_W'(FIRST_SCRATCH + s)) rd_word = store_q[s];
        end
    end

endmodule

// File: rtl/snd_evt_irq_ctrl.sv
module snd_evt_irq_ctrl
    import snd_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EVT-1:0]  evt_req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              fiq_o,
    output logic              core_rst_o,
    output logic              core_run_o
);

    wr_req_t wr;
    word_t   cur_q, run_q, scr_word;
    logic    clr_wr, cur_wr, run_wr;

    assign wr     = '{en: wr_en, addr: wr_addr, data: wr_data};
    assign clr_wr = wr.en && wr.addr == A_CLEAR;
    assign cur_wr = wr.en && wr.addr == A_CUR;
    assign run_wr = wr.en && wr.addr == A_RUN;

    evt_pending_unit u_pend (
        .clk       (clk),
        .rst       (rst),
        .req       (evt_req),
        .clr_wr    (clr_wr),
        .cur_wr    (cur_wr),
        .cur_wdata (wr.data),
        .cur_q     (cur_q),
        .fiq_q     (fiq_o)
    );

    run_ctrl_unit u_run (
        .clk        (clk),
        .rst        (rst),
        .run_wr     (run_wr),
        .run_wdata  (wr.data),
        .run_q      (run_q),
        .core_rst_q (core_rst_o)
    );

    scratch_regs u_scr (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_addr (rd_addr),
        .rd_word (scr_word)
    );

    assign core_run_o = ~run_q[0];

    always_comb begin
        case (rd_addr)
            A_CLEAR: rd_data = '0;
            A_CUR:   rd_data = cur_q;
            A_RUN:   rd_data = run_q;
            default: rd_data = scr_word;
        endcase
    end

    // R8: run output is the inverse of the hold bit
    a_r8_run_follows_hold: assert property (@(posedge clk) disable iff (rst)
        core_run_o != run_q[0]);

    // R9: clear address always reads zero
    a_r9_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == A_CLEAR) |-> rd_data == '0);

endmodule

// File: tb/snd_evt_irq_ctrl_test.sv
module snd_evt_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  evt_req = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd1;
    logic [31:0] rd_data;
    logic        fiq_o, core_rst_o, core_run_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    snd_evt_irq_ctrl uut (
        .clk(clk), .rst(rst), .evt_req(evt_req), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .fiq_o(fiq_o), .core_rst_o(core_rst_o),
        .core_run_o(core_run_o)
    );

    typedef struct {
        logic        fiq;
        logic [31:0] cur;
        logic        pulse;
        logic        run;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    // reference state derived from the requirements
    logic [7:0]  m_pend = '0;
    int          m_cnt  = 0;
    logic [31:0] m_cur  = '0;
    logic        m_fiq  = 1'b0;
    logic [31:0] m_run  = 32'd1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] req, input logic we, input logic [2:0] a,
                        input logic [31:0] d, input string tag);
        exp_t x;
        logic pulse;
        @(negedge clk);
        evt_req = req; wr_en = we; wr_addr = a; wr_data = d;
        // model update
        pulse = 1'b0;
        if (we && a == 3'd1) m_cur = d;
        if (we && a == 3'd2) begin
            pulse = m_run[0] && !d[0];
            m_run = d;
        end
        if (we && a == 3'd0) begin
            m_cnt = (m_cnt + 1) % 4;
            if (m_cnt == 0) begin
                for (int i = 0; i < 8; i++) begin
                    if (m_pend[i]) begin m_pend[i] = 1'b0; break; end
                end
                if (m_pend != 0) begin
                    for (int j = 0; j < 8; j++) begin
                        if (m_pend[j]) begin m_cur = j; break; end
                    end
                end else m_fiq = 1'b0;
            end
        end
        for (int e = 0; e < 8; e++) begin
            if (req[e]) begin
                m_pend[e] = 1'b1;
                m_fiq = 1'b1;
                if (m_cur == 0 || e < m_cur) m_cur = e;
            end
        end
        @(posedge clk);
        #1;
        x.fiq = m_fiq; x.cur = m_cur; x.pulse = pulse; x.run = ~m_run[0]; x.tag = tag;
        sb_q.push_back(x);
        @(negedge clk);
        evt_req = '0; wr_en = 1'b0;
    endtask

    task automatic clears(input int n, input string tag);
        for (int i = 0; i < n; i++) step(8'h00, 1'b1, 3'd0, 32'h0, tag);
    endtask

    task automatic read_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
        rd_addr = 3'd1;
    endtask

    // monitor: compare scoreboard items as results appear
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            exp_t x;
            x = sb_q.pop_front();
            check({x.tag, " fiq"},   {31'b0, fiq_o},      {31'b0, x.fiq});
            check({x.tag, " cur"},   rd_data,             x.cur);
            check({x.tag, " pulse"}, {31'b0, core_rst_o}, {31'b0, x.pulse});
            check({x.tag, " run"},   {31'b0, core_run_o}, {31'b0, x.run});
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R10 reset state
        #1;
        check("R10 fiq", {31'b0, fiq_o}, 32'd0);
        check("R10 cur", rd_data, 32'd0);
        check("R10 rst pulse", {31'b0, core_rst_o}, 32'd0);
        check("R10 run", {31'b0, core_run_o}, 32'd0);
        read_check(3'd2, 32'd1, "R10 run reg");

        // R1 R2 R3 single requests in mixed order
        step(8'b0010_0000, 1'b0, 3'd0, 0, "R2 R3 req5");
        step(8'b0000_0100, 1'b0, 3'd0, 0, "R3 req2 smaller");
        step(8'b0100_0000, 1'b0, 3'd0, 0, "R3 req6 larger kept");
        // R4 R5 R6 clears
        clears(3, "R4 early clears");
        clears(1, "R5 R6 clear to 5");
        clears(4, "R6 clear to 6");
        clears(4, "R7 clear empties");
        // R3 quirk: 0 and 3 together
        step(8'b0000_1001, 1'b0, 3'd0, 0, "R3 same-cycle 0 and 3");
        // R1 request with effective clear
        clears(3, "R4 pre clears");
        step(8'b1000_0000, 1'b1, 3'd0, 0, "R1 req with clear");
        clears(4, "R6 clear to 7");
        clears(4, "R7 clear empties again");
        // R9 R3: write cur then request
        step(8'h00, 1'b1, 3'd1, 32'h0, "R9 write cur zero");
        step(8'b0001_0000, 1'b0, 3'd0, 0, "R3 zero loads 4");
        step(8'h00, 1'b1, 3'd1, 32'hABCD_0123, "R9 cur store");
        // R8 run control
        step(8'h00, 1'b1, 3'd2, 32'h0, "R8 release pulse");
        step(8'h00, 1'b0, 3'd0, 0, "R8 pulse ends");
        step(8'h00, 1'b1, 3'd2, 32'h0, "R8 zero again no pulse");
        step(8'h00, 1'b1, 3'd2, 32'h5, "R8 hold");
        step(8'h00, 1'b1, 3'd2, 32'h4, "R8 release again");
        step(8'h00, 1'b0, 3'd0, 0, "R8 idle");
        read_check(3'd2, 32'h4, "R8 run reg value");
        // R9 scratch
        step(8'h00, 1'b1, 3'd3, 32'h1111_2222, "R9 wr3");
        step(8'h00, 1'b1, 3'd7, 32'hDEAD_BEEF, "R9 wr7");
        read_check(3'd3, 32'h1111_2222, "R9 rd3");
        read_check(3'd7, 32'hDEAD_BEEF, "R9 rd7");
        read_check(3'd5, 32'h0, "R9 rd5 untouched");
        read_check(3'd0, 32'h0, "R9 clear reads zero");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule